// File: doc/BRIEF.md
# Display Vertical Scan Timing Generator

This block runs the vertical half of a display controller's scan timing. An external horizontal counter sends it one pulse per finished line. On each pulse it steps a line position up to a programmable vertical total and then wraps it. On every wrap it also steps a 24-bit hardware frame counter. The blanking interval is set by a start line and an end line. It runs from the start line up to the last line, passes line 0, and stops at the end line. As a result, the frame counter changes partway through blanking and not at the point where blanking begins.

The block also produces three markers from the same position. A start-of-frame pulse lasts one clock. It lands a few lines before blanking ends, and its exact line depends on the scan mode, the scaler enable and the early-start controls. An advance level rises a programmable number of lines before the first visible line. A packed status word gives the line position and the low frame bits together, so that a single read sees a matching pair. In interlaced mode the position steps by two. The odd field starts at line 1 and the even field starts at line 0.

Top module: `vscan_timing`

## Requirements
- R1: After a synchronous active-low reset, the line position is 0, the frame counter is 0, the field flag is 0 (even) and the start-of-frame pulse is low.
- R2: In progressive mode, each clock that has both `run_en` and `line_tick` high moves the position up by 1. When the position would reach `vtotal`, it goes to 0 instead.
- R3: The frame counter (24 bits, wrapping) goes up by exactly 1 on the clock in which the position wraps. This is a wrap of the frame in progressive mode, or of the field in interlaced mode. It does not change on any other clock.
- R4: `vblank` is high while the position is at or above `blank_first`, or below `blank_last`. The setup assumes `blank_last` < `blank_first`.
- R5: In progressive mode, `sof` is high for exactly one clock. That clock follows the advancing edge that moves the position onto `blank_last - 2`. This holds even when that line is 0, which is the same clock as the frame step.
- R6: In progressive mode with both `scale_on` and `early_prog` high, the pulse line is `blank_last - 3`. If only one of the two is set, the pulse line stays at `blank_last - 2`.
- R7: In interlaced mode (`interlace` = 1), the position moves up by 2 on each advance. A wrap happens when position + 2 would reach `vtotal`. On a wrap the field flag toggles, and the new field starts at line 1 when odd and at line 0 when even.
- R8: In interlaced mode, the pulse line is whichever of `blank_last - 4` and `blank_last - 3` has the same parity (bit 0) as the field flag. When both `scale_on` and `early_intl` are high, the choice is between `blank_last - 6` and `blank_last - 5` instead. The setup assumes `blank_last` ≥ 6.
- R9: `adv_start` is high while the position is below `blank_last` and position + `adv_lines` ≥ `blank_last`. It is never high when `adv_lines` is 0.
- R10: `status_word` bits 12:0 carry the line position and bits 28:13 carry frame counter bits 15:0, both from the same clock.
- R11: While `run_en` is low, the position, field flag and frame counter do not change and `sof` stays low, even when `line_tick` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Master enable for all counting |
| line_tick | input | 1 | One-clock pulse per completed line |
| vtotal | input | 13 | Lines per frame (per field pair in interlaced mode) |
| blank_first | input | 13 | First blank line |
| blank_last | input | 13 | First visible line after blanking |
| interlace | input | 1 | Interlaced scan when high |
| scale_on | input | 1 | Scaler in use |
| early_prog | input | 1 | Early start line, progressive |
| early_intl | input | 1 | Early start line, interlaced |
| adv_lines | input | 4 | Lead of the advance marker in lines |
| vpos | output | 13 | Current line position |
| frame_count | output | 24 | Hardware frame counter |
| odd_field | output | 1 | Field flag, 1 for the odd field |
| vblank | output | 1 | Vertical blank level |
| sof | output | 1 | Start-of-frame pulse |
| adv_start | output | 1 | Advance marker level |
| status_word | output | 29 | Packed frame count and position |

## Verification
The start-of-frame pulse and the frame-counter step can fall on the same clock. This happens when the pulse line works out to line 0, which is the wrap line. The bench sets this up with `blank_last` = 2 in progressive mode. It then checks the edge on which the position returns to 0: `sof` must be high and the frame count must have gone up by one on that same edge, with neither event hiding the other. Every other configuration is swept through more than two full frames. At each line the bench compares all outputs against positions, fields and pulse lines that it computes by arithmetic.

// File: rtl/vscan_pkg.sv
// Shared widths for the vertical scan timing generator.
// Assumes: a single clock domain; line ticks arrive already synchronised.
package vscan_pkg;
    localparam int unsigned POS_W   = 13;
    localparam int unsigned FRAME_W = 24;
    localparam int unsigned STAT_FW = 16;
    localparam int unsigned ADV_W   = 4;
endpackage

// File: rtl/vscan_line_ctr.sv
// Line position and field counter.
// Steps by 1 (progressive) or 2 (interlaced) on each advance and wraps at
// vtotal. In interlaced mode the field flips on each wrap and the new field
// starts on its own parity line.
// Assumes vtotal >= 2.
module vscan_line_ctr #(
    parameter int unsigned POS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             interlace,
    input  logic [POS_W-1:0] vtotal,
    output logic [POS_W-1:0] vpos_q,
    output logic             field_q,
    output logic [POS_W-1:0] vpos_nx,
    output logic             field_nx,
    output logic             wrap
);
    logic [POS_W:0] ahead;
    logic           at_end;

    // Next position and wrap decision
    always_comb begin
        ahead    = {1'b0, vpos_q} + {{(POS_W-1){1'b0}}, interlace, ~interlace};
        at_end   = ahead >= {1'b0, vtotal};
        field_nx = (at_end && interlace) ? ~field_q : field_q;
        if (!at_end)
            vpos_nx = ahead[POS_W-1:0];
        else if (interlace)
            vpos_nx = {{(POS_W-1){1'b0}}, ~field_q};
        else
            vpos_nx = '0;
        wrap = step && at_end;
    end

    // Position and field registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpos_q  <= '0;
            field_q <= 1'b0;
        end else if (step) begin
            vpos_q  <= vpos_nx;
            field_q <= field_nx;
        end
    end
endmodule

// File: rtl/vscan_frame_ctr.sv
// Hardware frame counter: steps once per position wrap and rolls over at
// its full width.
module vscan_frame_ctr #(
    parameter int unsigned FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wrap,
    output logic [FRAME_W-1:0] count_q
);
    // Count wraps
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (wrap)
            count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/vscan_markers.sv
// Blank level, start-of-frame pulse and advance marker.
// The pulse line is picked by the scan mode, the field parity and the
// scaler/early-start controls.
// Assumes blank_last < blank_first and blank_last >= the largest offset used.
module vscan_markers #(
    parameter int unsigned POS_W = 13,
    parameter int unsigned ADV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             interlace,
    input  logic             scale_on,
    input  logic             early_prog,
    input  logic             early_intl,
    input  logic [POS_W-1:0] blank_first,
    input  logic [POS_W-1:0] blank_last,
    input  logic [ADV_W-1:0] adv_lines,
    input  logic [POS_W-1:0] vpos_q,
    input  logic [POS_W-1:0] vpos_nx,
    input  logic             field_nx,
    output logic             vblank,
    output logic             sof_q,
    output logic             adv_start
);
    logic [POS_W-1:0] offset;
    logic [POS_W-1:0] cand;
    logic [POS_W-1:0] target;
    logic [POS_W:0]   reach;

    // Pulse line for the position that is about to be entered
    always_comb begin
        if (interlace)
            offset = (scale_on && early_intl) ? POS_W'(6) : POS_W'(4);
        else
            offset = (scale_on && early_prog) ? POS_W'(3) : POS_W'(2);
        cand = blank_last - offset;
        if (interlace && (cand[0] != field_nx))
            target = cand + 1'b1;
        else
            target = cand;
    end

    // Blank level and advance marker from the present position
    always_comb begin
        vblank    = (vpos_q >= blank_first) || (vpos_q < blank_last);
        reach     = {1'b0, vpos_q} + {{(POS_W+1-ADV_W){1'b0}}, adv_lines};
        adv_start = (adv_lines != '0) && (vpos_q < blank_last)
                    && (reach >= {1'b0, blank_last});
    end

    // One-clock start-of-frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            sof_q <= 1'b0;
        else
            sof_q <= step && (vpos_nx == target);
    end
endmodule

// File: rtl/vscan_timing.sv
// Top level of the vertical scan timing generator.
// Combines the line/field counter, the frame counter and the markers, and
// packs the frame count and position into one status word.
// Assumes line_tick is a one-clock pulse from the horizontal counter.
module vscan_timing
    import vscan_pkg::*;
#(
    parameter int unsigned P_POS_W   = POS_W,
    parameter int unsigned P_FRAME_W = FRAME_W,
    parameter int unsigned P_STAT_FW = STAT_FW,
    parameter int unsigned P_ADV_W   = ADV_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_en,
    input  logic                          line_tick,
    input  logic [P_POS_W-1:0]            vtotal,
    input  logic [P_POS_W-1:0]            blank_first,
    input  logic [P_POS_W-1:0]            blank_last,
    input  logic                          interlace,
    input  logic                          scale_on,
    input  logic                          early_prog,
    input  logic                          early_intl,
    input  logic [P_ADV_W-1:0]            adv_lines,
    output logic [P_POS_W-1:0]            vpos,
    output logic [P_FRAME_W-1:0]          frame_count,
    output logic                          odd_field,
    output logic                          vblank,
    output logic                          sof,
    output logic                          adv_start,
    output logic [P_STAT_FW+P_POS_W-1:0]  status_word
);
    logic             step;
    logic [P_POS_W-1:0] vpos_nx;
    logic             field_nx;
    logic             wrap;

    assign step = run_en && line_tick;

    vscan_line_ctr #(.POS_W(P_POS_W)) u_line (
        .clk(clk), .rst_n(rst_n), .step(step), .interlace(interlace),
        .vtotal(vtotal), .vpos_q(vpos), .field_q(odd_field),
        .vpos_nx(vpos_nx), .field_nx(field_nx), .wrap(wrap)
    );

    vscan_frame_ctr #(.FRAME_W(P_FRAME_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .count_q(frame_count)
    );

    vscan_markers #(.POS_W(P_POS_W), .ADV_W(P_ADV_W)) u_mark (
        .clk(clk), .rst_n(rst_n), .step(step), .interlace(interlace),
        .scale_on(scale_on), .early_prog(early_prog), .early_intl(early_intl),
        .blank_first(blank_first), .blank_last(blank_last),
        .adv_lines(adv_lines), .vpos_q(vpos), .vpos_nx(vpos_nx),
        .field_nx(field_nx), .vblank(vblank), .sof_q(sof),
        .adv_start(adv_start)
    );

    // Both fields come from registers updated on the same edge
    assign status_word = {frame_count[P_STAT_FW-1:0], vpos};
endmodule

// File: rtl/vscan_timing_chk.sv
// Assertion checker bound to the vertical scan timing generator.
module vscan_timing_chk #(
    parameter int unsigned P_POS_W   = 13,
    parameter int unsigned P_FRAME_W = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_en,
    input logic [P_POS_W-1:0]   vtotal,
    input logic [P_POS_W-1:0]   vpos,
    input logic [P_FRAME_W-1:0] frame_count,
    input logic                 odd_field,
    input logic                 vblank,
    input logic                 sof
);
    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> vpos < vtotal); // R2

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && frame_count != $past(frame_count))
        |-> (frame_count == $past(frame_count) + 1'b1) && (vpos < $past(vpos))); // R3

    AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && odd_field != $past(odd_field))
        |-> frame_count == $past(frame_count) + 1'b1); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_en))
        |-> $stable(vpos) && $stable(frame_count) && !sof); // R11

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof); // R5

    AST_SOF_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> vblank); // R4
endmodule

bind vscan_timing vscan_timing_chk #(.P_POS_W(P_POS_W), .P_FRAME_W(P_FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .vtotal(vtotal), .vpos(vpos),
    .frame_count(frame_count), .odd_field(odd_field), .vblank(vblank), .sof(sof)
);

// File: tb/vscan_timing_bench.sv
`timescale 1ns/1ps
module vscan_timing_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        line_tick = 1'b0;
    logic [12:0] vtotal = 13'd20;
    logic [12:0] blank_first = 13'd16;
    logic [12:0] blank_last = 13'd5;
    logic        interlace = 1'b0;
    logic        scale_on = 1'b0;
    logic        early_prog = 1'b0;
    logic        early_intl = 1'b0;
    logic [3:0]  adv_lines = 4'd0;
    logic [12:0] vpos;
    logic [23:0] frame_count;
    logic        odd_field;
    logic        vblank;
    logic        sof;
    logic        adv_start;
    logic [28:0] status_word;

    int n_cmp = 0;
    int n_bad = 0;
    int m_pos, m_field, m_frame;
    bit done = 0;
    bit saw_joint = 0;

    always #2 clk = ~clk;

    vscan_timing u_vscan_timing (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .line_tick(line_tick),
        .vtotal(vtotal), .blank_first(blank_first), .blank_last(blank_last),
        .interlace(interlace), .scale_on(scale_on), .early_prog(early_prog),
        .early_intl(early_intl), .adv_lines(adv_lines), .vpos(vpos),
        .frame_count(frame_count), .odd_field(odd_field), .vblank(vblank),
        .sof(sof), .adv_start(adv_start), .status_word(status_word)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pulse_line();
        int t;
        if (!interlace)
            t = int'(blank_last) - ((scale_on && early_prog) ? 3 : 2);
        else begin
            t = int'(blank_last) - ((scale_on && early_intl) ? 6 : 4);
            if ((t % 2) != m_field) t = t + 1;
        end
        return t;
    endfunction

    task automatic check_all(input bit was_tick);
        bit e_blank, e_adv, e_sof;
        e_blank = (m_pos >= int'(blank_first)) || (m_pos < int'(blank_last));
        e_adv   = (adv_lines != 0) && (m_pos < int'(blank_last))
                  && (m_pos + int'(adv_lines) >= int'(blank_last));
        e_sof   = was_tick && (m_pos == pulse_line());
        chk(interlace ? "R7 position" : "R2 position", vpos, m_pos);
        chk("R7 field", odd_field, m_field);
        chk("R3 frame", frame_count, m_frame);
        chk("R4 vblank", vblank, e_blank);
        chk("R9 adv_start", adv_start, e_adv);
        chk(interlace ? "R8 sof" : ((scale_on || early_prog) ? "R6 sof" : "R5 sof"), sof, e_sof);
        chk("R10 status", status_word, (longint'(m_frame % 65536) * 8192) + m_pos);
    endtask

    task automatic one_tick();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
        if (run_en) begin
            if (!interlace) begin
                if (m_pos + 1 >= int'(vtotal)) begin
                    m_pos = 0; m_frame++;
                end else m_pos++;
            end else begin
                if (m_pos + 2 >= int'(vtotal)) begin
                    m_field = 1 - m_field; m_pos = m_field; m_frame++;
                end else m_pos += 2;
            end
        end
        check_all(run_en);
    endtask

    task automatic run_cfg(input int vt, input int bf, input int bl, input bit il,
                           input bit sc, input bit ep, input bit ei, input int adv);
        @(negedge clk);
        rst_n = 1'b0; run_en = 1'b0;
        vtotal = 13'(vt); blank_first = 13'(bf); blank_last = 13'(bl);
        interlace = il; scale_on = sc; early_prog = ep; early_intl = ei;
        adv_lines = 4'(adv);
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1; run_en = 1'b1;
        m_pos = 0; m_field = 0; m_frame = 0;
        check_all(1'b0); // R1 reset state
        for (int i = 0; i < 2 * vt + 5; i++) begin
            one_tick();
            if (sof && frame_count != 0 && vpos == 0) saw_joint = 1;
        end
    endtask

    initial begin
        // Progressive, plain pulse at blank_last-2 (R5), advance lead 4 (R9)
        run_cfg(20, 16, 5, 0, 0, 0, 0, 4);
        // Progressive, scaler + early: blank_last-3 (R6)
        run_cfg(20, 16, 5, 0, 1, 1, 0, 3);
        // Progressive, early without scaler: stays blank_last-2 (R6)
        run_cfg(20, 16, 5, 0, 0, 1, 0, 0);
        // Progressive, scaler without early (R6)
        run_cfg(20, 16, 5, 0, 1, 0, 1, 15);
        // Pulse line 0 coincides with the frame step (R5, R3)
        run_cfg(12, 9, 2, 0, 0, 0, 0, 2);
        chk("R5 pulse on wrap edge seen", saw_joint, 1);
        // Interlaced, odd vtotal, plain (R7, R8)
        run_cfg(21, 16, 9, 1, 0, 0, 0, 5);
        // Interlaced, scaler + early: blank_last-6/-5 (R8)
        run_cfg(21, 16, 9, 1, 1, 0, 1, 2);
        // Interlaced, early without scaler (R8)
        run_cfg(20, 15, 8, 1, 0, 1, 1, 1);
        // Enable low: ticks ignored (R11)
        run_en = 1'b0;
        for (int i = 0; i < 6; i++) one_tick();
        run_en = 1'b1;
        for (int i = 0; i < 3; i++) one_tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule